// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a general purpose I/O peripheral sitting behind an APB slave port. It serves up to 32 pins. Each pin has its own 8-bit setup word. That word picks whether the pin drives, listens, or both, and whether its pad buffer is enabled. It also holds an interrupt enable and a three-bit trigger mode. Pin inputs pass through a two-flop synchroniser before any software read or event detection.

Detected events are latched per pin in a pending word. The pending bits drive a per-pin interrupt vector, and software clears them by writing ones. Bulk setup words load one value into every implemented pin, or into a group of eight pins. Separate set and clear words change single output bits without a read-modify-write. The pin count is a parameter. Registers and bits that belong to absent pins read as zero and ignore writes.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset, `gpio_o`, `gpio_oe_o` and `irq_o` are all zero, and the output, pending and setup words read zero.
- R2: The setup word of pin i sits at byte offset 4*i. It stores bits 7:0 of the written data, and bits 31:8 read as zero.
- R3: For pins at or above NUM_PORTS, setup words read zero and ignore writes. Bits at or above NUM_PORTS read zero in the pending, input and output words.
- R4: Setup bits control the pin path. Bit 0 gates the output register onto `gpio_o`. Bit 2 drives `gpio_oe_o`. Bit 1 gates the synchronised pin into the input word. So 0x2 is input only, 0x5 is output only, 0x7 is bidirectional driving, and 0x3 is bidirectional at high impedance with the input still readable.
- R5: The input word at 0x84 shows the pins two clocks after they change. It is read only, and a write to it changes nothing.
- R6: The output word at 0x88 can be read and written. A write to 0xA4 sets the output bits written as one. A write to 0xA0 clears the output bits written as one. Every other output bit is left unchanged.
- R7: A write to 0x8C loads bits 7:0 into every implemented setup word. A write to 0x90+4*n loads them into the setup words of pins 8n to 8n+7 only.
- R8: Setup bits 7:5 select the trigger: 0 level high, 1 level low, 2 rising edge, 3 falling edge, 4 both edges. An event sets the pin's bit in the pending word at 0x80 and on `irq_o` only when both setup bit 3 (interrupt enable) and bit 1 (input enable) are set.
- R9: A pending bit stays set until a one is written to its position at 0x80. Writing zero leaves it set. If an edge event occurs in the same cycle as its clear, the event wins and the bit stays set.
- R10: In level modes, the pending bit sets again on every cycle the level condition holds, including right after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| gpio_i | input | NUM_PORTS | Pin inputs (asynchronous) |
| gpio_o | output | NUM_PORTS | Pin output values |
| gpio_oe_o | output | NUM_PORTS | Pad output buffer enables |
| irq_o | output | NUM_PORTS | Per-pin pending interrupt vector |

## Verification
A corrupt setup word shows up as soon as the next clock. It changes `gpio_o` or `gpio_oe_o` directly, and it also shows on readback of that pin's word. A fault in the synchroniser, the previous-value flop or the trigger decode shows up in the third clock after a pin change. In that clock the pending word and `irq_o` either gain a bit they should not have or miss one they should. A pending bit that fails to hold or to clear reveals itself on the next read of 0x80. The bench aligns a pin edge exactly with a clear to expose a wrong priority between the two.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  localparam int CFG_W = 8;

  // setup word bit positions
  localparam int CFG_OUT_EN = 0;
  localparam int CFG_IN_EN  = 1;
  localparam int CFG_BUF_EN = 2;
  localparam int CFG_IRQ_EN = 3;
  localparam int CFG_TRIG_LO = 5;
  localparam int CFG_TRIG_HI = 7;

  typedef enum logic [2:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // word indices (byte offset / 4)
  localparam int WIDX_PEND  = 32;
  localparam int WIDX_IN    = 33;
  localparam int WIDX_OUT   = 34;
  localparam int WIDX_ALL   = 35;
  localparam int WIDX_GRP0  = 36;
  localparam int NUM_GRP    = 4;
  localparam int WIDX_CLR   = 40;
  localparam int WIDX_SET   = 41;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_apb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             pin_i,
  input  logic             clr_i,
  output logic             in_o,
  output logic             pend_o
);
  logic  prev_q, pend_q, in_en, hit, evt;
  trig_e mode;
  logic  unused_cfg;

  assign unused_cfg = ^{cfg_i[4], cfg_i[CFG_BUF_EN], cfg_i[CFG_OUT_EN]};
  assign in_en = cfg_i[CFG_IN_EN];
  assign mode  = trig_e'(cfg_i[CFG_TRIG_HI:CFG_TRIG_LO]);
  assign in_o  = pin_i & in_en;

  always_comb begin
    unique case (mode)
      TRIG_HIGH: hit = in_en & pin_i;
      TRIG_LOW:  hit = in_en & ~pin_i;
      TRIG_RISE: hit = in_en & pin_i & ~prev_q;
      TRIG_FALL: hit = in_en & ~pin_i & prev_q;
      TRIG_BOTH: hit = in_en & (pin_i ^ prev_q);
      default:   hit = 1'b0;
    endcase
  end

  assign evt = hit & cfg_i[CFG_IRQ_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      pend_q <= evt | (pend_q & ~clr_i);  // new event beats a clear
    end
  end

  assign pend_o = pend_q;

  // R9
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);

  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[CFG_IRQ_EN] && !pend_q) |=> !pend_q);
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [ADDR_W-1:0]    paddr_i,
  input  logic [31:0]          pwdata_i,
  output logic [31:0]          prdata_o,
  input  logic [NUM_PORTS-1:0] gpio_i,
  output logic [NUM_PORTS-1:0] gpio_o,
  output logic [NUM_PORTS-1:0] gpio_oe_o,
  output logic [NUM_PORTS-1:0] irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]    widx;
  logic                 unused_lsb;
  logic                 wr, wr_pend, wr_out, wr_all, wr_set, wr_clr;
  logic [NUM_GRP-1:0]   wr_grp;
  logic [NUM_PORTS-1:0] wd, out_q, pin_s, in_vis, pend;
  logic [CFG_W-1:0]     cfg_q [NUM_PORTS];

  assign widx       = paddr_i[ADDR_W-1:2];
  assign unused_lsb = ^paddr_i[1:0];
  assign wd         = pwdata_i[NUM_PORTS-1:0];
  assign wr         = psel_i & penable_i & pwrite_i;
  assign wr_pend    = wr && (widx == WORD_W'(WIDX_PEND));
  assign wr_out     = wr && (widx == WORD_W'(WIDX_OUT));
  assign wr_all     = wr && (widx == WORD_W'(WIDX_ALL));
  assign wr_set     = wr && (widx == WORD_W'(WIDX_SET));
  assign wr_clr     = wr && (widx == WORD_W'(WIDX_CLR));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign wr_grp[g] = wr && (widx == WORD_W'(WIDX_GRP0 + g));
  end

  gpio_sync #(.W(NUM_PORTS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_s)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic wr_own;
    assign wr_own = wr && (widx == WORD_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cfg_q[i] <= '0;
      else if (wr_own || wr_all || wr_grp[i/8]) cfg_q[i] <= pwdata_i[CFG_W-1:0];
    end

    gpio_irq_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cfg_i (cfg_q[i]),
      .pin_i (pin_s[i]),
      .clr_i (wr_pend & pwdata_i[i]),
      .in_o  (in_vis[i]),
      .pend_o(pend[i])
    );

    assign gpio_o[i]    = out_q[i] & cfg_q[i][CFG_OUT_EN];
    assign gpio_oe_o[i] = cfg_q[i][CFG_BUF_EN];

    // R7
    cfg_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_all |=> (cfg_q[i] == $past(pwdata_i[CFG_W-1:0])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= '0;
    else if (wr_out) out_q <= wd;
    else if (wr_set) out_q <= out_q | wd;
    else if (wr_clr) out_q <= out_q & ~wd;
  end

  assign irq_o = pend;

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      for (int i = 0; i < NUM_PORTS; i++)
        if (widx == WORD_W'(i)) prdata_o = 32'(cfg_q[i]);
      if (widx == WORD_W'(WIDX_PEND)) prdata_o = 32'(pend);
      if (widx == WORD_W'(WIDX_IN))   prdata_o = 32'(in_vis);
      if (widx == WORD_W'(WIDX_OUT))  prdata_o = 32'(out_q);
    end
  end

  // R6
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((out_q & $past(wd)) == $past(wd)));

  // R6
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((out_q & $past(wd)) == '0));

  // R6
  set_keeps_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((out_q & ~$past(wd)) == $past(out_q & ~wd)));
endmodule

// File: tb/test_gpio_apb_ctrl.sv
`timescale 1ns/1ps
module test_gpio_apb_ctrl;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [N-1:0] gpio_in, gpio_out, gpio_oe, irq;

  always #2.5 clk = ~clk;

  gpio_apb_ctrl #(.NUM_PORTS(N), .ADDR_W(12)) i_gpio_apb_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares read data in the access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", prdata);
      end else begin
        chk(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [11:0] a, logic [31:0] e, string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(posedge clk); #1;
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    gpio_in = '0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);

    // R1 reset state
    chk("R1 gpio_o", 32'(gpio_out), 32'h0);
    chk("R1 gpio_oe_o", 32'(gpio_oe), 32'h0);
    chk("R1 irq_o", 32'(irq), 32'h0);
    apb_rd(12'h088, 32'h0, "R1 out word");
    apb_rd(12'h080, 32'h0, "R1 pend word");
    apb_rd(12'h000, 32'h0, "R1 setup word");

    // R2 per-pin setup word
    apb_wr(12'h014, 32'hFFFF_FF05);
    apb_rd(12'h014, 32'h0000_0005, "R2 setup pin5");

    // R3 absent pins
    apb_wr(12'h078, 32'h0000_0003);
    apb_rd(12'h078, 32'h0, "R3 setup pin30");
    apb_wr(12'h088, 32'hFFFF_FFFF);
    apb_rd(12'h088, 32'h00FF_FFFF, "R3 out word upper");

    // R4 pin path
    wait_cyc(1);
    chk("R4 out only gpio_o", 32'(gpio_out), 32'h20);
    chk("R4 out only oe", 32'(gpio_oe), 32'h20);
    apb_wr(12'h018, 32'h07);
    gpio_in = 24'h0000C0;
    wait_cyc(3);
    chk("R4 bidir gpio_o", 32'(gpio_out), 32'h60);
    chk("R4 bidir oe", 32'(gpio_oe), 32'h60);
    apb_rd(12'h084, 32'h40, "R4 input gating");
    apb_wr(12'h018, 32'h03);
    wait_cyc(1);
    chk("R4 hiz oe", 32'(gpio_oe), 32'h20);
    apb_rd(12'h084, 32'h40, "R4 hiz input readable");
    apb_wr(12'h018, 32'h02);
    wait_cyc(1);
    chk("R4 in only gpio_o", 32'(gpio_out), 32'h20);

    // R5 input word read only
    apb_wr(12'h084, 32'hFFFF_FFFF);
    apb_rd(12'h084, 32'h40, "R5 input after write");
    apb_rd(12'h088, 32'h00FF_FFFF, "R5 out untouched");

    // R6 output word, set and clear
    apb_wr(12'h088, 32'h0000_0F00);
    apb_rd(12'h088, 32'h0000_0F00, "R6 out write");
    apb_wr(12'h0A4, 32'hFF00_0003);
    apb_rd(12'h088, 32'h0000_0F03, "R6 set bits");
    apb_wr(12'h0A0, 32'h0000_0100);
    apb_rd(12'h088, 32'h0000_0E03, "R6 clear bits");

    // R7 bulk setup
    apb_wr(12'h08C, 32'h02);
    apb_rd(12'h000, 32'h02, "R7 all pin0");
    apb_rd(12'h05C, 32'h02, "R7 all pin23");
    apb_rd(12'h060, 32'h00, "R7 all pin24 absent");
    apb_wr(12'h094, 32'h05);
    apb_rd(12'h020, 32'h05, "R7 group1 pin8");
    apb_rd(12'h03C, 32'h05, "R7 group1 pin15");
    apb_rd(12'h01C, 32'h02, "R7 group1 pin7 kept");
    apb_rd(12'h040, 32'h02, "R7 group1 pin16 kept");
    chk("R7 group oe", 32'(gpio_oe), 32'h0000_FF00);

    // R8 trigger modes
    gpio_in = 24'h00000A;
    wait_cyc(4);
    apb_wr(12'h000, 32'h0A);  // level high
    apb_wr(12'h004, 32'h2A);  // level low
    apb_wr(12'h008, 32'h4A);  // rise
    apb_wr(12'h00C, 32'h6A);  // fall
    apb_wr(12'h010, 32'h8A);  // both
    wait_cyc(4);
    apb_rd(12'h080, 32'h0, "R8 idle pend");
    chk("R8 idle irq_o", 32'(irq), 32'h0);
    gpio_in = 24'h000015;
    wait_cyc(4);
    apb_rd(12'h080, 32'h1F, "R8 all modes fire");
    chk("R8 irq_o", 32'(irq), 32'h1F);

    // R10 level re-asserts after clear
    apb_wr(12'h080, 32'h1F);
    apb_rd(12'h080, 32'h03, "R10 level persists");

    // R9 hold and write-one clear
    gpio_in = 24'h000001;
    wait_cyc(4);
    apb_rd(12'h080, 32'h13, "R9 both-edge fall");
    apb_wr(12'h080, 32'h0);
    apb_rd(12'h080, 32'h13, "R9 zero write holds");
    apb_wr(12'h080, 32'h10);
    apb_rd(12'h080, 32'h03, "R9 one write clears");

    // R9 edge coincides with clear
    gpio_in = 24'h000005;
    apb_wr(12'h080, 32'h04);
    apb_rd(12'h080, 32'h07, "R9 event beats clear");
    apb_wr(12'h080, 32'h04);
    apb_rd(12'h080, 32'h03, "R9 clear without event");

    // R8 interrupt enable off
    apb_wr(12'h014, 32'h42);
    gpio_in = 24'h000025;
    wait_cyc(4);
    apb_rd(12'h080, 32'h03, "R8 masked pin5");

    // R10 level gone, clear sticks
    gpio_in = 24'h000024;
    wait_cyc(4);
    apb_wr(12'h080, 32'h01);
    apb_rd(12'h080, 32'h02, "R10 level low only");

    wait_cyc(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule